// File: doc/BRIEF.md
# Scan-Driven SRAM Test Controller

This block gives test access to up to sixteen on-chip SRAM macros through one 112-bit command word. The word is either shifted in one bit per clock on a serial pin or taken in one cycle from a wide parallel bus. A load strobe then starts a single memory access that the word describes. Macros 0 to 7 are dual-ported, with one read/write port and one read-only port, and share the left bus. Macros 8 to 15 are single-ported and share the right bus. Two cycles later, the read data of the selected macro is written back into the data fields of the word. The word can then be shifted out serially or read from the parallel output bus.

Chip-select and write-enable are active low. A 4-bit select field drives one chip-select line low for exactly one clock. That line is on the left bus when select bit 3 is 0 and on the right bus when it is 1. Every other line stays high. All inputs are synchronous to one clock.

The command word, from bit 111 down to bit 0, holds these fields:

| Bits | Field |
|------|-------|
| 111:108 | select |
| 107:92 | port-A address |
| 91:60 | port-A data |
| 59 | port-A chip-select-n |
| 58 | port-A write-enable-n |
| 57:54 | port-A byte mask |
| 53:38 | port-B address |
| 37:6 | port-B data |
| 5 | port-B chip-select-n |
| 4 | port-B write-enable-n |
| 3:0 | port-B byte mask |

Top module: `sram_scan_ctrl`

## Requirements
- R1: While `rst` is high, and after it, the word reads all zeros. Every chip-select output and every write-enable output is 1.
- R2: With `path_sel`=1 and `scan_en`=1, the word shifts left on each clock and `scan_in` enters at bit 0. A word therefore loads MSB first in 112 clocks.
- R3: With `path_sel`=0 and `par_load`=1, the word takes `par_in` in one clock. `scan_in` has no effect in that clock.
- R4: A `load_stb` accepted in the idle state drives exactly one chip-select low, for exactly one cycle, starting the cycle after the strobe. That line is bit (select mod 8) of the left vector when select bit 3 is 0, or of the right vector when it is 1. Port A gives that line only when port-A chip-select-n (bit 59) is 0. On the left bus, port B gives `l_cs_n1` only when bit 5 is 0.
- R5: A port-A write (bit 59 = 0, bit 58 = 0) drives the selected bus's write-enable low in the access cycle. Address, data and the 4-bit byte mask are presented from the word, and mask bit k enables byte k.
- R6: For a port-A read (bit 59 = 0, bit 58 = 1), the selected macro's port-A read data replaces bits 91:60 two clocks after the accepted strobe. For a port-B read on the left bus (bit 5 = 0), the left port-B read data replaces bits 37:6.
- R7: A port-B read aimed at a right-bus macro drives no chip-select. It writes zero into bits 37:6.
- R8: A port that is not reading leaves its data field unchanged. This covers a write, or chip-select-n = 1.
- R9: In the capture clock, capture takes priority over serial shift and parallel load. The word then holds the captured value, unshifted.
- R10: `scan_out` always shows bit 111 of the word, so a shift emits the word MSB first. `frame_out` shows all 112 bits.
- R11: `load_stb` is ignored while an access is in progress. Holding it high for three cycles gives exactly one chip-select pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| path_sel | input | 1 | 1 = serial load path, 0 = parallel load path |
| scan_en | input | 1 | Serial shift enable |
| scan_in | input | 1 | Serial data in |
| par_load | input | 1 | Parallel load enable |
| par_in | input | 112 | Parallel command word |
| load_stb | input | 1 | Starts one memory access |
| left_rd0 | input | 256 | Port-A read data of left macros, 32 bits each, macro 0 lowest |
| left_rd1 | input | 256 | Port-B read data of left macros |
| right_rd0 | input | 256 | Read data of right macros |
| l_addr0 | output | 16 | Left port-A address |
| l_din0 | output | 32 | Left port-A write data |
| l_we_n0 | output | 1 | Left port-A write-enable, active low |
| l_mask0 | output | 4 | Left port-A byte mask |
| l_cs_n0 | output | 8 | Left port-A chip-selects, active low |
| l_addr1 | output | 16 | Left port-B (read-only) address |
| l_cs_n1 | output | 8 | Left port-B chip-selects, active low |
| r_addr0 | output | 16 | Right address |
| r_din0 | output | 32 | Right write data |
| r_we_n0 | output | 1 | Right write-enable, active low |
| r_mask0 | output | 4 | Right byte mask |
| r_cs_n0 | output | 8 | Right chip-selects, active low |
| scan_out | output | 1 | Serial out, word bit 111 |
| frame_out | output | 112 | Whole command word |

## Verification
The read-data capture and the serial shift can both want the word register in the same clock. The bench raises `scan_en` with `scan_in`=1 exactly in the capture clock of a read access. It then expects the word to equal the captured result with no shift applied. A second collision holds `load_stb` high through a whole access. Exactly one chip-select pulse must appear, counted by a monitor that samples every cycle. Random write/read sequences are checked against a shadow memory kept by the bench.

// File: rtl/sst_pkg.sv
package sst_pkg;
  parameter int SEL_W  = 4;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 32;
  parameter int MASK_W = 4;
  localparam int NMACRO = 2 ** SEL_W;
  localparam int SIDE_N = NMACRO / 2;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] a0;
    logic [DATA_W-1:0] d0;
    logic              cs0_n;
    logic              we0_n;
    logic [MASK_W-1:0] m0;
    logic [ADDR_W-1:0] a1;
    logic [DATA_W-1:0] d1;
    logic              cs1_n;
    logic              we1_n;
    logic [MASK_W-1:0] m1;
  } frame_t;

  localparam int FRAME_W = $bits(frame_t);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_CAP} acc_state_t;
endpackage

// File: rtl/sst_cs_decode.sv
module sst_cs_decode #(
  parameter int IDX_W = 4,
  localparam int OUT_N = 2 ** IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_N-1:0] sel_n
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign sel_n[g] = !(en && (idx == IDX_W'(g)));
  end
endmodule

// File: rtl/sst_frame_reg.sv
module sst_frame_reg
  import sst_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          path_sel,
  input  logic          scan_en,
  input  logic          scan_in,
  input  logic          par_load,
  input  frame_t        par_in,
  input  logic          cap_en0,
  input  logic          cap_en1,
  input  logic [DW-1:0] cap_d0,
  input  logic [DW-1:0] cap_d1,
  output frame_t        frame_q
);
  logic cap_any, do_shift, do_par;
  assign cap_any  = cap_en0 | cap_en1;
  assign do_shift = !cap_any && path_sel && scan_en;
  assign do_par   = !cap_any && !path_sel && par_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (cap_any) begin
      if (cap_en0) frame_q.d0 <= cap_d0;
      if (cap_en1) frame_q.d1 <= cap_d1;
    end else if (do_shift) begin
      frame_q <= {frame_q[FRAME_W-2:0], scan_in};
    end else if (do_par) begin
      frame_q <= par_in;
    end
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    do_shift |=> frame_q[0] == $past(scan_in)); // R2
  AST_CAP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (cap_en0 && scan_en) |=> frame_q.d0 == $past(cap_d0)); // R9
  AST_CAP_KEEPS_OTHER: assert property (@(posedge clk) disable iff (rst)
    (cap_en0 && !cap_en1) |=> $stable(frame_q.d1)); // R8
endmodule

// File: rtl/sst_seq.sv
module sst_seq
  import sst_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int MW = MASK_W,
  localparam int SN = 2 ** (SW - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_stb,
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] a0,
  input  logic [DW-1:0] d0,
  input  logic          cs0_n,
  input  logic          we0_n,
  input  logic [MW-1:0] m0,
  input  logic [AW-1:0] a1,
  input  logic          cs1_n,
  output logic [AW-1:0] l_addr0,
  output logic [DW-1:0] l_din0,
  output logic          l_we_n0,
  output logic [MW-1:0] l_mask0,
  output logic [SN-1:0] l_cs_n0,
  output logic [AW-1:0] l_addr1,
  output logic [SN-1:0] l_cs_n1,
  output logic [AW-1:0] r_addr0,
  output logic [DW-1:0] r_din0,
  output logic          r_we_n0,
  output logic [MW-1:0] r_mask0,
  output logic [SN-1:0] r_cs_n0,
  output logic [SW-1:0] sel_q,
  output logic          cap_en0,
  output logic          cap_en1
);
  acc_state_t state;
  logic go, right;
  logic rd0_q, rd1_q;
  logic [2*SN-1:0] dec0_n;
  logic [SN-1:0]   dec1_n;

  assign go    = (state == ST_IDLE) && load_stb;
  assign right = sel[SW-1];

  sst_cs_decode #(.IDX_W(SW)) u_dec0 (
    .en(!cs0_n), .idx(sel), .sel_n(dec0_n));
  sst_cs_decode #(.IDX_W(SW-1)) u_dec1 (
    .en(!cs1_n && !right), .idx(sel[SW-2:0]), .sel_n(dec1_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      l_cs_n0 <= '1;
      l_cs_n1 <= '1;
      r_cs_n0 <= '1;
      l_we_n0 <= 1'b1;
      r_we_n0 <= 1'b1;
      l_addr0 <= '0;
      l_din0  <= '0;
      l_mask0 <= '0;
      l_addr1 <= '0;
      r_addr0 <= '0;
      r_din0  <= '0;
      r_mask0 <= '0;
      sel_q   <= '0;
      rd0_q   <= 1'b0;
      rd1_q   <= 1'b0;
      cap_en0 <= 1'b0;
      cap_en1 <= 1'b0;
    end else begin
      l_cs_n0 <= '1;
      l_cs_n1 <= '1;
      r_cs_n0 <= '1;
      l_we_n0 <= 1'b1;
      r_we_n0 <= 1'b1;
      cap_en0 <= 1'b0;
      cap_en1 <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          state   <= ST_ISSUE;
          l_cs_n0 <= dec0_n[SN-1:0];
          r_cs_n0 <= dec0_n[2*SN-1:SN];
          l_cs_n1 <= dec1_n;
          l_we_n0 <= right | cs0_n | we0_n;
          r_we_n0 <= !right | cs0_n | we0_n;
          l_addr0 <= a0;
          l_din0  <= d0;
          l_mask0 <= m0;
          l_addr1 <= a1;
          r_addr0 <= a0;
          r_din0  <= d0;
          r_mask0 <= m0;
          sel_q   <= sel;
          rd0_q   <= !cs0_n && we0_n;
          rd1_q   <= !cs1_n;
        end
        ST_ISSUE: begin
          state   <= ST_CAP;
          cap_en0 <= rd0_q;
          cap_en1 <= rd1_q;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(~{l_cs_n0, r_cs_n0}) <= 1); // R4
  AST_CS_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(&{l_cs_n0, l_cs_n1, r_cs_n0}) |=> &{l_cs_n0, l_cs_n1, r_cs_n0}); // R4
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !l_we_n0 |-> !(&l_cs_n0)); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && load_stb) |=> state != ST_ISSUE); // R11
endmodule

// File: rtl/sram_scan_ctrl.sv
module sram_scan_ctrl
  import sst_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int MW = MASK_W,
  localparam int SN = 2 ** (SW - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               path_sel,
  input  logic               scan_en,
  input  logic               scan_in,
  input  logic               par_load,
  input  logic [FRAME_W-1:0] par_in,
  input  logic               load_stb,
  input  logic [SN*DW-1:0]   left_rd0,
  input  logic [SN*DW-1:0]   left_rd1,
  input  logic [SN*DW-1:0]   right_rd0,
  output logic [AW-1:0]      l_addr0,
  output logic [DW-1:0]      l_din0,
  output logic               l_we_n0,
  output logic [MW-1:0]      l_mask0,
  output logic [SN-1:0]      l_cs_n0,
  output logic [AW-1:0]      l_addr1,
  output logic [SN-1:0]      l_cs_n1,
  output logic [AW-1:0]      r_addr0,
  output logic [DW-1:0]      r_din0,
  output logic               r_we_n0,
  output logic [MW-1:0]      r_mask0,
  output logic [SN-1:0]      r_cs_n0,
  output logic               scan_out,
  output logic [FRAME_W-1:0] frame_out
);
  frame_t          frame_q;
  logic [SW-1:0]   sel_q;
  logic            cap_en0, cap_en1;
  logic [DW-1:0]   cap_d0, cap_d1;
  logic [SW-2:0]   idx;

  assign idx    = sel_q[SW-2:0];
  assign cap_d0 = sel_q[SW-1] ? right_rd0[idx*DW +: DW] : left_rd0[idx*DW +: DW];
  assign cap_d1 = sel_q[SW-1] ? '0 : left_rd1[idx*DW +: DW];

  sst_frame_reg #(.DW(DW)) u_frame (
    .clk(clk), .rst(rst), .path_sel(path_sel), .scan_en(scan_en),
    .scan_in(scan_in), .par_load(par_load), .par_in(frame_t'(par_in)),
    .cap_en0(cap_en0), .cap_en1(cap_en1), .cap_d0(cap_d0), .cap_d1(cap_d1),
    .frame_q(frame_q));

  sst_seq #(.SW(SW), .AW(AW), .DW(DW), .MW(MW)) u_seq (
    .clk(clk), .rst(rst), .load_stb(load_stb),
    .sel(frame_q.sel), .a0(frame_q.a0), .d0(frame_q.d0),
    .cs0_n(frame_q.cs0_n), .we0_n(frame_q.we0_n), .m0(frame_q.m0),
    .a1(frame_q.a1), .cs1_n(frame_q.cs1_n),
    .l_addr0(l_addr0), .l_din0(l_din0), .l_we_n0(l_we_n0), .l_mask0(l_mask0),
    .l_cs_n0(l_cs_n0), .l_addr1(l_addr1), .l_cs_n1(l_cs_n1),
    .r_addr0(r_addr0), .r_din0(r_din0), .r_we_n0(r_we_n0), .r_mask0(r_mask0),
    .r_cs_n0(r_cs_n0), .sel_q(sel_q), .cap_en0(cap_en0), .cap_en1(cap_en1));

  assign scan_out  = frame_q[FRAME_W-1];
  assign frame_out = frame_q;

  AST_RIGHT_NO_PORTB: assert property (@(posedge clk) disable iff (rst)
    !(&r_cs_n0) |-> (&l_cs_n1)); // R7
endmodule

// File: tb/sram_scan_ctrl_bench.sv
module sram_scan_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic path_sel = 1'b1, scan_en = 1'b0, scan_in = 1'b0, par_load = 1'b0, load_stb = 1'b0;
  logic [111:0] par_in = '0;
  logic [255:0] left_rd0 = '0, left_rd1 = '0, right_rd0 = '0;
  logic [15:0] l_addr0, l_addr1, r_addr0;
  logic [31:0] l_din0, r_din0;
  logic l_we_n0, r_we_n0, scan_out;
  logic [3:0] l_mask0, r_mask0;
  logic [7:0] l_cs_n0, l_cs_n1, r_cs_n0;
  logic [111:0] frame_out;

  int checks = 0, errors = 0, pulses = 0;
  bit finished = 0;
  logic [31:0] mem [16][64];
  logic [31:0] sh  [16][64];
  logic [7:0] snap_l0, snap_l1, snap_r0;
  logic snap_lwe, snap_rwe;

  always #4 clk = ~clk;

  sram_scan_ctrl u_sram_scan_ctrl (
    .clk(clk), .rst(rst), .path_sel(path_sel), .scan_en(scan_en), .scan_in(scan_in),
    .par_load(par_load), .par_in(par_in), .load_stb(load_stb),
    .left_rd0(left_rd0), .left_rd1(left_rd1), .right_rd0(right_rd0),
    .l_addr0(l_addr0), .l_din0(l_din0), .l_we_n0(l_we_n0), .l_mask0(l_mask0),
    .l_cs_n0(l_cs_n0), .l_addr1(l_addr1), .l_cs_n1(l_cs_n1),
    .r_addr0(r_addr0), .r_din0(r_din0), .r_we_n0(r_we_n0), .r_mask0(r_mask0),
    .r_cs_n0(r_cs_n0), .scan_out(scan_out), .frame_out(frame_out));

  // behavioural memories: left macros dual-port, right macros single-port
  initial for (int m = 0; m < 16; m++) for (int a = 0; a < 64; a++) begin
    mem[m][a] = '0; sh[m][a] = '0;
  end
  always @(posedge clk) begin
    for (int m = 0; m < 8; m++) begin
      if (!l_cs_n0[m]) begin
        if (!l_we_n0) begin
          for (int k = 0; k < 4; k++)
            if (l_mask0[k]) mem[m][l_addr0[5:0]][8*k +: 8] <= l_din0[8*k +: 8];
        end else left_rd0[32*m +: 32] <= mem[m][l_addr0[5:0]];
      end
      if (!l_cs_n1[m]) left_rd1[32*m +: 32] <= mem[m][l_addr1[5:0]];
      if (!r_cs_n0[m]) begin
        if (!r_we_n0) begin
          for (int k = 0; k < 4; k++)
            if (r_mask0[k]) mem[8+m][r_addr0[5:0]][8*k +: 8] <= r_din0[8*k +: 8];
        end else right_rd0[32*m +: 32] <= mem[8+m][r_addr0[5:0]];
      end
    end
  end
  always @(negedge clk) if (!(&{l_cs_n0, l_cs_n1, r_cs_n0})) pulses++;

  function automatic logic [111:0] mk(input logic [3:0] s, input logic [15:0] a0,
      input logic [31:0] d0, input logic c0, input logic w0, input logic [3:0] m0,
      input logic [15:0] a1, input logic [31:0] d1, input logic c1, input logic w1,
      input logic [3:0] m1);
    return {s, a0, d0, c0, w0, m0, a1, d1, c1, w1, m1};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
      input logic [3:0] mk4);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (mk4[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  function automatic logic [7:0] onecold(input int i);
    return ~(8'd1 << i);
  endfunction

  task automatic check(input string req, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_in(input logic [111:0] f);
    path_sel = 1'b1;
    for (int j = 0; j < 112; j++) begin
      @(negedge clk); scan_en = 1'b1; scan_in = f[111-j];
    end
    @(negedge clk); scan_en = 1'b0; scan_in = 1'b0;
  endtask

  // strobe at N0; chip-selects seen at N1; capture edge between N2 and N3
  task automatic access(input bit collide);
    @(negedge clk); load_stb = 1'b1;
    @(negedge clk); load_stb = 1'b0;
    snap_l0 = l_cs_n0; snap_l1 = l_cs_n1; snap_r0 = r_cs_n0;
    snap_lwe = l_we_n0; snap_rwe = r_we_n0;
    @(negedge clk);
    if (collide) begin path_sel = 1'b1; scan_en = 1'b1; scan_in = 1'b1; end
    @(negedge clk); scan_en = 1'b0; scan_in = 1'b0;
  endtask

  task automatic do_write(input int m, input logic [15:0] a, input logic [31:0] d,
      input logic [3:0] mk4);
    logic [111:0] f;
    f = mk(4'(m), a, d, 1'b0, 1'b0, mk4, 16'h0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_in(f);
    access(0);
    sh[m][a[5:0]] = merge(sh[m][a[5:0]], d, mk4);
    check("R5 we_n", {111'd0, (m < 8) ? snap_lwe : snap_rwe}, 112'd0);
    check("R4 cs", {88'd0, snap_l0, snap_l1, snap_r0},
          {88'd0, (m < 8) ? onecold(m) : 8'hFF, 8'hFF, (m < 8) ? 8'hFF : onecold(m - 8)});
    check("R8 write keeps word", frame_out, f);
  endtask

  task automatic do_read(input int m, input logic [15:0] a, input logic [15:0] b,
      input bit collide);
    logic [111:0] f, e;
    f = mk(4'(m), a, 32'hDEAD_0000 | m, 1'b0, 1'b1, 4'h0, b, 32'h1234_5678, 1'b0, 1'b1, 4'h0);
    e = mk(4'(m), a, sh[m][a[5:0]], 1'b0, 1'b1, 4'h0, b,
           (m < 8) ? sh[m][b[5:0]] : 32'h0, 1'b0, 1'b1, 4'h0);
    shift_in(f);
    access(collide);
    check(collide ? "R9 capture over shift" : (m < 8 ? "R6 read" : "R7 right read"),
          frame_out, e);
    check("R4 cs read", {88'd0, snap_l0, snap_l1, snap_r0},
          {88'd0, (m < 8) ? onecold(m) : 8'hFF, (m < 8) ? onecold(m) : 8'hFF,
           (m < 8) ? 8'hFF : onecold(m - 8)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset word", frame_out, '0);
    check("R1 reset strobes", {84'd0, l_cs_n0, l_cs_n1, r_cs_n0, l_we_n0, r_we_n0, 2'b0},
          {84'd0, 24'hFFFFFF, 2'b11, 2'b0});
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", frame_out, '0);

    // R2: serial load
    begin
      logic [111:0] f = {$urandom, $urandom, $urandom, 16'(($urandom))};
      f[59] = 1'b1; f[5] = 1'b1;
      shift_in(f);
      check("R2 serial load", frame_out, f);
      // R10: serial shift-out, MSB first
      begin
        logic [111:0] got;
        check("R10 parallel view", frame_out, f);
        for (int j = 0; j < 112; j++) begin
          @(negedge clk); got[111-j] = scan_out; scan_en = 1'b1; scan_in = 1'b0;
        end
        @(negedge clk); scan_en = 1'b0;
        check("R10 serial out", got, f);
      end
    end

    // R3: parallel load, serial pin ignored
    begin
      logic [111:0] f = mk(4'd3, 16'h1, 32'hA5A5_5A5A, 1'b1, 1'b1, 4'h0,
                           16'h2, 32'h0F0F_F0F0, 1'b1, 1'b1, 4'h0);
      @(negedge clk); path_sel = 1'b0; par_in = f; par_load = 1'b1; scan_en = 1'b1; scan_in = 1'b1;
      @(negedge clk); par_load = 1'b0; scan_en = 1'b0; scan_in = 1'b0; path_sel = 1'b1;
      check("R3 parallel load", frame_out, f);
      // R8: both ports disabled, no capture, no pulse
      pulses = 0;
      access(0);
      check("R8 idle access keeps word", frame_out, f);
      check("R8 no chip-select", {80'd0, 32'(pulses)}, '0);
    end

    // directed: two addresses in left macro 2 and right macro 11
    do_write(2, 16'd1, 32'h0000_0001, 4'hF);
    do_write(2, 16'd2, 32'h0000_0002, 4'hF);
    do_read(2, 16'd1, 16'd2, 0);
    do_write(11, 16'd5, 32'hCAFE_F00D, 4'hF);
    do_read(11, 16'd5, 16'd6, 0);
    do_write(2, 16'd1, 32'hFFFF_FFFF, 4'b0101);
    do_read(2, 16'd1, 16'd1, 0);
    do_read(7, 16'd9, 16'd9, 1);

    // R11: strobe held high over the whole access
    begin
      logic [111:0] f = mk(4'd5, 16'h3, 32'h0, 1'b0, 1'b1, 4'h0, 16'h4, 32'h0, 1'b1, 1'b1, 4'h0);
      shift_in(f);
      pulses = 0;
      @(negedge clk); load_stb = 1'b1;
      repeat (3) @(negedge clk);
      load_stb = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 single pulse", {80'd0, 32'(pulses)}, 112'd1);
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      int m = $urandom_range(0, 15);
      logic [15:0] a = 16'($urandom_range(0, 63));
      logic [15:0] b = 16'($urandom_range(0, 63));
      if ($urandom_range(0, 1)) do_write(m, a, $urandom, 4'($urandom_range(1, 15)));
      else do_read(m, a, b, ($urandom_range(0, 7) == 0));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule